// File: doc/BRIEF.md
# Processor Control and Status Register Bank

This block keeps the control and status registers of a 32-bit RISC core. Software and the rest of the core read any register combinationally by a 5-bit index. The core writes through one port made of an enable, an index, a 32-bit data word and a debug qualifier. Each register applies its own write rule:

- Saved program counters drop bit 0.
- Status copies keep only their defined fields.
- The cause register changes only under debug access.
- One scratch register keeps the magnitude of what it is given, unless the write is a debug write.
- The cache-control register reflects back only its enable bit.
- Identification registers return fixed constants.
- Unused indices read as zero.

The status word is held as separate flag fields. A built-in evaluator turns a 4-bit branch condition code into a single taken/not-taken bit from those flags. Synchronous reset loads the documented defaults. The block also presents the program counter value the core starts from after reset.

The block has no sequencing of its own. Every write completes on the clock edge where it is accepted, and every read is a pure function of the index and the current register contents.

Top module: `sysreg_bank`

## Requirements
- R1: After synchronous active-high reset, the cause register (index 4) reads 0x0000FFF0 and the status word (index 5) reads 0x00008000. Indices 0-3, 24, 25, 29 and 31 read 0. `boot_pc` carries 0xFFFFFFF0.
- R2: Writes to the exception PC (index 0), the fatal PC (index 2) and the address-trap register (index 25) store the data with bit 0 forced to 0.
- R3: The exception status copy (index 1), the fatal status copy (index 3) and the status word (index 5) keep only the bits in the mask 0x000FF3FF. The status word flags are placed as follows: Z bit 0, S bit 1, OV bit 2, CY bit 3, then float flags in bits 4-9, ID bit 12, AE bit 13, EP bit 14, NP bit 15, and interrupt level in bits 19:16.
- R4: Index 6 always reads 0x00005346, index 7 always reads 0x000000E0 and index 30 always reads 0x00000004. Writes to these indices change nothing.
- R5: The cause register holds the fatal cause in bits 31:16 and the exception cause in bits 15:0. A write with `wr_dbg` low leaves it unchanged. A write with `wr_dbg` high stores all 32 bits.
- R6: A write to index 31 with `wr_dbg` low stores the two's-complement magnitude of the data. With `wr_dbg` high it stores the data unchanged. Index 29 stores all 32 bits.
- R7: The cache-control register (index 24) reads back write bit 1 at bit 1, and every other bit reads as zero.
- R8: Indices 8-23 and 26-28 read as zero, and writes to them change nothing.
- R9: Condition codes 0-7 give OV, CY, Z, CY|Z, S, 1, OV|S and (OV^S)|Z. Codes 8-15 give the inverse of code minus 8.
- R10: A write takes effect at the rising clock edge only while `wr_en` is high. Reads follow `rd_idx` with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 32 | Write data |
| wr_dbg | input | 1 | Debug-write qualifier |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 32 | Read data |
| cond_code | input | 4 | Branch condition code |
| cond_true | output | 1 | Condition result |
| boot_pc | output | 32 | Program counter value after reset |

## Verification
Write rules are tried with all-ones data, which shows exactly which bits each mask keeps. Odd values separate the bit-0 clearing from plain storage. The same negative and positive words are written with and without the debug qualifier, which distinguishes magnitude storage, raw storage and the debug-only cause register. The condition evaluator is swept over all 16 codes under flag patterns with no flags set, one flag set, OV and S together, and all flags set. This separates each OR and XOR term and the inversion of the upper eight codes.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int XLEN  = 32;
    localparam int IDX_W = 5;

    // register index map
    localparam logic [IDX_W-1:0] IDX_EXC_PC   = 5'd0;
    localparam logic [IDX_W-1:0] IDX_EXC_PSW  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_FAT_PC   = 5'd2;
    localparam logic [IDX_W-1:0] IDX_FAT_PSW  = 5'd3;
    localparam logic [IDX_W-1:0] IDX_CAUSE    = 5'd4;
    localparam logic [IDX_W-1:0] IDX_STATUS   = 5'd5;
    localparam logic [IDX_W-1:0] IDX_CPU_ID   = 5'd6;
    localparam logic [IDX_W-1:0] IDX_TASK_CTL = 5'd7;
    localparam logic [IDX_W-1:0] IDX_CACHE    = 5'd24;
    localparam logic [IDX_W-1:0] IDX_TRAP_ADR = 5'd25;
    localparam logic [IDX_W-1:0] IDX_SCR_A    = 5'd29;
    localparam logic [IDX_W-1:0] IDX_FIXED_C  = 5'd30;
    localparam logic [IDX_W-1:0] IDX_SCR_B    = 5'd31;

    localparam int STAT_W = 20;
    localparam logic [XLEN-1:0] STAT_MASK = 32'h000F_F3FF;

    // status word flags, MSB first so the struct maps onto bits 19:0
    typedef struct packed {
        logic [3:0] ilvl;
        logic       np;
        logic       ep;
        logic       ae;
        logic       id;
        logic [1:0] rsv;
        logic       fro;
        logic       fiv;
        logic       fzd;
        logic       fov;
        logic       fud;
        logic       fpr;
        logic       cy;
        logic       ov;
        logic       s;
        logic       z;
    } stat_t;

    function automatic stat_t stat_from_word(input logic [XLEN-1:0] w);
        stat_t t;
        t     = stat_t'(w[STAT_W-1:0]);
        t.rsv = 2'b00;
        return t;
    endfunction

    function automatic logic [XLEN-1:0] stat_to_word(input stat_t t);
        return {{(XLEN-STAT_W){1'b0}}, t};
    endfunction

endpackage

// File: rtl/sysreg_cond.sv
module sysreg_cond
    import sysreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] code,
    input  stat_t      flags,
    output logic       taken
);

    logic base;

    always_comb begin
        unique case (code[2:0])
            3'd0: base = flags.ov;
            3'd1: base = flags.cy;
            3'd2: base = flags.z;
            3'd3: base = flags.cy | flags.z;
            3'd4: base = flags.s;
            3'd5: base = 1'b1;
            3'd6: base = flags.ov | flags.s;
            default: base = (flags.ov ^ flags.s) | flags.z;
        endcase
        taken = base ^ code[3];
    end

    AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
        (code == 4'd5) |-> taken) else $error("always code false"); // R9
    AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
        (code == 4'd13) |-> !taken) else $error("never code true"); // R9

endmodule

// File: rtl/sysreg_status.sv
module sysreg_status
    import sysreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [XLEN-1:0] data,
    output stat_t           flags
);

    stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q    <= '0;
            stat_q.np <= 1'b1;
        end else if (wr) begin
            stat_q <= stat_from_word(data);
        end
    end

    assign flags = stat_q;

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(stat_q)) else $error("status changed without write"); // R10
    AST_STATUS_RSV: assert property (@(posedge clk) disable iff (rst)
        stat_q.rsv == 2'b00) else $error("status reserved bits set"); // R3

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter logic [31:0] BOOT_PC     = 32'hFFFF_FFF0,
    parameter logic [15:0] EXC_CAUSE0  = 16'hFFF0,
    parameter logic [31:0] CPU_ID_VAL  = 32'h0000_5346,
    parameter logic [31:0] TASK_CTL_VAL = 32'h0000_00E0,
    parameter logic [31:0] FIXED_C_VAL = 32'h0000_0004
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        wr_dbg,
    input  logic [4:0]  rd_idx,
    output logic [31:0] rd_data,
    input  logic [3:0]  cond_code,
    output logic        cond_true,
    output logic [31:0] boot_pc
);

    localparam logic [XLEN-1:0] PC_MASK = ~{{(XLEN-1){1'b0}}, 1'b1};

    logic [XLEN-1:0] exc_pc_q, fat_pc_q, trap_adr_q;
    logic [XLEN-1:0] exc_psw_q, fat_psw_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] scr_a_q, scr_b_q;
    logic            cache_en_q;
    stat_t           flags;

    logic            hit_stat;
    logic [XLEN-1:0] mag;

    assign hit_stat = wr_en && (wr_idx == IDX_STATUS);
    assign mag      = wr_data[XLEN-1] ? (~wr_data + 1'b1) : wr_data;

    sysreg_status u_status (
        .clk   (clk),
        .rst   (rst),
        .wr    (hit_stat),
        .data  (wr_data),
        .flags (flags)
    );

    sysreg_cond u_cond (
        .clk   (clk),
        .rst   (rst),
        .code  (cond_code),
        .flags (flags),
        .taken (cond_true)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_pc_q   <= '0;
            fat_pc_q   <= '0;
            trap_adr_q <= '0;
            exc_psw_q  <= '0;
            fat_psw_q  <= '0;
            cause_q    <= {16'h0000, EXC_CAUSE0};
            scr_a_q    <= '0;
            scr_b_q    <= '0;
            cache_en_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_idx)
                IDX_EXC_PC:   exc_pc_q   <= wr_data & PC_MASK;
                IDX_FAT_PC:   fat_pc_q   <= wr_data & PC_MASK;
                IDX_TRAP_ADR: trap_adr_q <= wr_data & PC_MASK;
                IDX_EXC_PSW:  exc_psw_q  <= wr_data & STAT_MASK;
                IDX_FAT_PSW:  fat_psw_q  <= wr_data & STAT_MASK;
                IDX_CAUSE:    if (wr_dbg) cause_q <= wr_data;
                IDX_SCR_A:    scr_a_q    <= wr_data;
                IDX_SCR_B:    scr_b_q    <= wr_dbg ? wr_data : mag;
                IDX_CACHE:    cache_en_q <= wr_data[1];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_idx)
            IDX_EXC_PC:   rd_data = exc_pc_q;
            IDX_EXC_PSW:  rd_data = exc_psw_q;
            IDX_FAT_PC:   rd_data = fat_pc_q;
            IDX_FAT_PSW:  rd_data = fat_psw_q;
            IDX_CAUSE:    rd_data = cause_q;
            IDX_STATUS:   rd_data = stat_to_word(flags);
            IDX_CPU_ID:   rd_data = CPU_ID_VAL;
            IDX_TASK_CTL: rd_data = TASK_CTL_VAL;
            IDX_CACHE:    rd_data = {{(XLEN-2){1'b0}}, cache_en_q, 1'b0};
            IDX_TRAP_ADR: rd_data = trap_adr_q;
            IDX_SCR_A:    rd_data = scr_a_q;
            IDX_FIXED_C:  rd_data = FIXED_C_VAL;
            IDX_SCR_B:    rd_data = scr_b_q;
            default:      rd_data = '0;
        endcase
    end

    assign boot_pc = BOOT_PC;

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (rst)
        !exc_pc_q[0] && !fat_pc_q[0] && !trap_adr_q[0]) else $error("odd saved pc"); // R2
    AST_PSW_COPY_MASK: assert property (@(posedge clk) disable iff (rst)
        ((exc_psw_q | fat_psw_q) & ~STAT_MASK) == '0) else $error("status copy mask"); // R3
    AST_CAUSE_DEBUG_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dbg && wr_idx == IDX_CAUSE) |=> $stable(cause_q)) else $error("cause written"); // R5
    AST_SCR_MAGNITUDE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dbg && wr_idx == IDX_SCR_B && wr_data != 32'h8000_0000) |=> !scr_b_q[XLEN-1])
        else $error("negative magnitude"); // R6
    AST_CACHE_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_CACHE) |-> ((rd_data & ~32'h2) == '0)) else $error("cache readback"); // R7

endmodule

// File: tb/test_sysreg_bank.sv
module test_sysreg_bank;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        wr_dbg;
    logic [4:0]  rd_idx;
    logic [31:0] rd_data;
    logic [3:0]  cond_code;
    logic        cond_true;
    logic [31:0] boot_pc;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sysreg_bank i_sysreg_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_dbg(wr_dbg), .rd_idx(rd_idx), .rd_data(rd_data), .cond_code(cond_code),
        .cond_true(cond_true), .boot_pc(boot_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d, input logic dbg);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_dbg = dbg;
        @(negedge clk);
        wr_en = 1'b0; wr_dbg = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] idx, input logic [31:0] exp);
        rd_idx = idx;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 cause", 5'd4, 32'h0000FFF0);
        rd_chk("R1 status", 5'd5, 32'h00008000);
        rd_chk("R1 exc pc", 5'd0, 32'h0);
        rd_chk("R1 fat psw", 5'd3, 32'h0);
        rd_chk("R1 cache", 5'd24, 32'h0);
        rd_chk("R1 scr b", 5'd31, 32'h0);
        chk("R1 boot pc", boot_pc, 32'hFFFFFFF0);
    endtask

    task automatic t_pc_mask;
        wr(5'd0, 32'h12345679, 1'b0); rd_chk("R2 exc pc", 5'd0, 32'h12345678);
        wr(5'd2, 32'hFFFFFFFF, 1'b0); rd_chk("R2 fat pc", 5'd2, 32'hFFFFFFFE);
        wr(5'd25, 32'h00000003, 1'b1); rd_chk("R2 trap adr", 5'd25, 32'h00000002);
    endtask

    task automatic t_stat_mask;
        wr(5'd1, 32'hFFFFFFFF, 1'b0); rd_chk("R3 exc psw", 5'd1, 32'h000FF3FF);
        wr(5'd3, 32'hFFFFFFFF, 1'b0); rd_chk("R3 fat psw", 5'd3, 32'h000FF3FF);
        wr(5'd5, 32'hFFFFFFFF, 1'b0); rd_chk("R3 status all", 5'd5, 32'h000FF3FF);
        wr(5'd5, 32'h00050C09, 1'b0); rd_chk("R3 status fields", 5'd5, 32'h00050009);
    endtask

    task automatic t_consts;
        wr(5'd6, 32'h0, 1'b1);  rd_chk("R4 cpu id", 5'd6, 32'h00005346);
        wr(5'd7, 32'hFFFFFFFF, 1'b0); rd_chk("R4 task ctl", 5'd7, 32'h000000E0);
        wr(5'd30, 32'h0, 1'b0); rd_chk("R4 fixed", 5'd30, 32'h00000004);
    endtask

    task automatic t_cause;
        wr(5'd4, 32'h12345678, 1'b0); rd_chk("R5 normal write ignored", 5'd4, 32'h0000FFF0);
        wr(5'd4, 32'h12345678, 1'b1); rd_chk("R5 debug write", 5'd4, 32'h12345678);
    endtask

    task automatic t_scratch;
        wr(5'd31, 32'hFFFFFFFB, 1'b0); rd_chk("R6 magnitude", 5'd31, 32'h00000005);
        wr(5'd31, 32'h00000007, 1'b0); rd_chk("R6 positive", 5'd31, 32'h00000007);
        wr(5'd31, 32'hFFFFFFFB, 1'b1); rd_chk("R6 debug raw", 5'd31, 32'hFFFFFFFB);
        wr(5'd29, 32'hDEADBEEF, 1'b0); rd_chk("R6 scr a", 5'd29, 32'hDEADBEEF);
    endtask

    task automatic t_cache;
        wr(5'd24, 32'hFFFFFFFF, 1'b0); rd_chk("R7 cache set", 5'd24, 32'h00000002);
        wr(5'd24, 32'hFFFFFFFD, 1'b0); rd_chk("R7 cache clear", 5'd24, 32'h00000000);
    endtask

    task automatic t_unimpl;
        wr(5'd12, 32'hFFFFFFFF, 1'b1);
        wr(5'd27, 32'hFFFFFFFF, 1'b0);
        for (int i = 8; i <= 28; i++)
            if (i < 24 || i > 25) rd_chk("R8 unimplemented", 5'(i), 32'h0);
        rd_chk("R8 neighbour scr a", 5'd29, 32'hDEADBEEF);
    endtask

    task automatic t_no_enable;
        @(negedge clk);
        wr_en = 1'b0; wr_idx = 5'd0; wr_data = 32'hAAAA5554; wr_dbg = 1'b1;
        rd_idx = 5'd0;
        @(negedge clk);
        chk("R10 no write without enable", rd_data, 32'h12345678);
        wr_idx = 5'd29;
        @(negedge clk);
        rd_idx = 5'd29; #1;
        chk("R10 read follows index", rd_data, 32'hDEADBEEF);
    endtask

    function automatic logic exp_cond(input logic [3:0] c, input logic [3:0] f);
        logic z, s, ov, cy, b;
        z = f[0]; s = f[1]; ov = f[2]; cy = f[3];
        case (c[2:0])
            3'd0: b = ov;
            3'd1: b = cy;
            3'd2: b = z;
            3'd3: b = cy | z;
            3'd4: b = s;
            3'd5: b = 1'b1;
            3'd6: b = ov | s;
            default: b = (ov ^ s) | z;
        endcase
        return c[3] ? ~b : b;
    endfunction

    task automatic t_cond(input logic [3:0] f);
        wr(5'd5, {28'h0, f}, 1'b0);
        for (int c = 0; c < 16; c++) begin
            cond_code = 4'(c);
            #1;
            chk($sformatf("R9 code %0d flags %h", c, f), {31'h0, cond_true}, {31'h0, exp_cond(4'(c), f)});
        end
    endtask

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_dbg = 1'b0;
        rd_idx = '0; cond_code = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pc_mask();
        t_stat_mask();
        t_consts();
        t_cause();
        t_scratch();
        t_cache();
        t_unimpl();
        t_no_enable();
        t_cond(4'h0); t_cond(4'h1); t_cond(4'h2); t_cond(4'h4);
        t_cond(4'h8); t_cond(4'h6); t_cond(4'hF);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule